// File: doc/BRIEF.md
# Output-Compare Pin Action Controller

This block is the output stage of an eight-channel timer. A free-running 16-bit counter, held inside the block, is compared every cycle against one 16-bit compare value per channel. When a channel's compare value equals the counter, the block applies that channel's programmed pin action on the next clock edge. The action is one of four: do nothing, toggle, drive low or drive high. The result goes into a one-bit output latch for that channel.

Software programs the actions through two 8-bit control registers on a small register bus. The bus has one address bit, a write strobe, write data and read data. Each channel has a veto input (mask) that suspends its action. Any channel that is live takes over its pin, whatever the port direction says. The pin is then driven as an output carrying the latch value. A channel that is switched off or masked passes the port direction and port data straight through, so the pin stays free for other functions. Each channel also raises a sticky match flag, which is cleared by a write-one-to-clear input.

Top module: `oc_pin_ctrl`

## Requirements
- R1: Both control registers reset to 0x00. A write takes effect on the next clock edge. Reads are combinational and allowed at any time, and return the stored byte for `reg_addr_i`.
- R2: Address 0 holds channels 7..4 and address 1 holds channels 3..0. Channel n occupies bits [2*(n%4)+1 : 2*(n%4)] of its register. The upper bit of each pair is the mode bit and the lower bit is the level bit.
- R3: The action codes are written {mode, level}. On a match of a live channel, code 01 inverts the latch, 10 loads 0 and 11 loads 1. Code 00 never alters the latch.
- R4: The counter is 0 while reset is held, then adds 1 per clock and wraps. A channel matches in the cycle where the counter equals its compare value, and `pin_o` shows the new latch value after the following rising edge.
- R5: A channel is live when its code is not 00 and its mask bit is 0. A live channel drives `pin_oe_o`=1 and `pin_o`=latch, regardless of `port_dir_i`.
- R6: While a channel's mask bit is 1, a match leaves its latch unchanged, and its pin follows `port_dir_i`/`port_data_i`.
- R7: With code 00, `pin_oe_o[n]` equals `port_dir_i[n]` and `pin_o[n]` equals `port_data_i[n]`.
- R8: Every channel latch resets to 0. Rewriting a channel's code changes its latch only through a later match.
- R9: A match sets `match_flag_o[n]` on the next edge, and the flag stays set until `flag_clr_i[n]`=1 clears it at an edge. If a match and a clear arrive in the same cycle, the flag stays set. Flags reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control register write strobe |
| reg_addr_i | input | 1 | Control register select |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| cmp_flat_i | input | 128 | Compare values, channel n at bits [16n+15:16n] |
| mask_i | input | 8 | Per-channel action veto |
| flag_clr_i | input | 8 | Write-one-to-clear for the match flags |
| port_dir_i | input | 8 | Port direction, 1 = output |
| port_data_i | input | 8 | Port data |
| pin_o | output | 8 | Pin data |
| pin_oe_o | output | 8 | Pin output enable |
| match_flag_o | output | 8 | Sticky match flags |

## Verification
Read data, pin data and output enable follow the inputs and the stored state within the same cycle. Latch values, flags and register contents change one edge after the cycle that causes them, whether that cause is a match, a clear or a write. The bench drives inputs just after a falling edge and samples all outputs 1 ns later. It compares them against a behavioural model whose state advances once per cycle, using the inputs of that cycle. Each check therefore sees the model state that reflects exactly the edges already taken. The directed checks target the same-cycle match-and-clear case, a code rewrite without a match, and the reset values.

// File: rtl/oc_pkg.sv
`timescale 1ns/1ps
package oc_pkg;
  typedef enum logic [1:0] {
    ACT_OFF    = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } oc_act_e;
endpackage

// File: rtl/oc_counter.sv
`timescale 1ns/1ps
module oc_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  p_cnt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/oc_ctrl_regs.sv
`timescale 1ns/1ps
module oc_ctrl_regs
  import oc_pkg::*;
#(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned ADDR_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output oc_act_e           act_o [N_CH]
);
  localparam int unsigned CH_PER_REG = REG_W / 2;
  localparam int unsigned N_REG      = N_CH / CH_PER_REG;

  logic [REG_W-1:0] reg_q [N_REG];
  logic             addr_ok;

  assign addr_ok = int'(addr_i) < int'(N_REG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < int'(N_REG); r++) reg_q[r] <= '0;
    end else if (we_i && addr_ok) begin
      reg_q[addr_i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_ok) rdata_o = reg_q[addr_i];
  end

  // highest channels live at address 0; mode bit above level bit
  for (genvar n = 0; n < int'(N_CH); n++) begin : g_map
    localparam int unsigned RI = N_REG - 1 - n / CH_PER_REG;
    localparam int unsigned BI = 2 * (n % CH_PER_REG);
    assign act_o[n] = oc_act_e'(reg_q[RI][BI+1:BI]);
  end

  p_wr_lands_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_ok) |=> reg_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/oc_channel.sv
`timescale 1ns/1ps
module oc_channel
  import oc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  oc_act_e          act_i,
  input  logic             mask_i,
  input  logic             clr_i,
  input  logic             dir_i,
  input  logic             data_i,
  output logic             pin_o,
  output logic             oe_o,
  output logic             flag_o
);
  logic hit, live, lat_q, flag_q;

  assign hit  = (cnt_i == cmp_i);
  assign live = (act_i != ACT_OFF) && !mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= 1'b0;
    end else if (hit && live) begin
      unique case (act_i)
        ACT_TOGGLE: lat_q <= ~lat_q;
        ACT_CLEAR:  lat_q <= 1'b0;
        ACT_SET:    lat_q <= 1'b1;
        default:    lat_q <= lat_q;
      endcase
    end
  end

  // a match in the same cycle outranks the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= hit | (flag_q & ~clr_i);
  end

  assign pin_o  = live ? lat_q : data_i;
  assign oe_o   = live | dir_i;
  assign flag_o = flag_q;

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit && live) |=> $stable(lat_q));
  p_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i |=> $stable(lat_q));
  p_tog_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && live && act_i == ACT_TOGGLE) |=> lat_q != $past(lat_q));
  p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && live && act_i == ACT_SET) |=> lat_q);
  p_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && live && act_i == ACT_CLEAR) |=> !lat_q);
  p_flag_hit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> flag_o);
  p_flag_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  p_flag_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && clr_i && !hit) |=> !flag_o);
  p_live_oe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live |-> oe_o);
endmodule

// File: rtl/oc_pin_ctrl.sv
`timescale 1ns/1ps
module oc_pin_ctrl
  import oc_pkg::*;
#(
  parameter  int unsigned N_CH   = 8,
  parameter  int unsigned CNT_W  = 16,
  parameter  int unsigned REG_W  = 8,
  localparam int unsigned N_REG  = N_CH / (REG_W / 2),
  localparam int unsigned ADDR_W = (N_REG > 1) ? $clog2(N_REG) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [REG_W-1:0]      reg_wdata_i,
  output logic [REG_W-1:0]      reg_rdata_o,
  input  logic [N_CH*CNT_W-1:0] cmp_flat_i,
  input  logic [N_CH-1:0]       mask_i,
  input  logic [N_CH-1:0]       flag_clr_i,
  input  logic [N_CH-1:0]       port_dir_i,
  input  logic [N_CH-1:0]       port_data_i,
  output logic [N_CH-1:0]       pin_o,
  output logic [N_CH-1:0]       pin_oe_o,
  output logic [N_CH-1:0]       match_flag_o
);
  logic [CNT_W-1:0] cnt;
  oc_act_e          act [N_CH];

  oc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt)
  );

  oc_ctrl_regs #(.N_CH(N_CH), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .act_o  (act)
  );

  for (genvar n = 0; n < int'(N_CH); n++) begin : g_ch
    oc_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cnt_i (cnt),
      .cmp_i (cmp_flat_i[n*CNT_W +: CNT_W]),
      .act_i (act[n]),
      .mask_i(mask_i[n]),
      .clr_i (flag_clr_i[n]),
      .dir_i (port_dir_i[n]),
      .data_i(port_data_i[n]),
      .pin_o (pin_o[n]),
      .oe_o  (pin_oe_o[n]),
      .flag_o(match_flag_o[n])
    );

    p_off_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act[n] == ACT_OFF) |-> (pin_oe_o[n] == port_dir_i[n] && pin_o[n] == port_data_i[n]));
  end
endmodule

// File: tb/sim_oc_pin_ctrl.sv
`timescale 1ns/1ps
module sim_oc_pin_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [0:0]  addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic [7:0]  mask = '0, clr = '0, dir = '0, dat = '0;
  logic [7:0]  pin, oe, flg;
  logic [15:0] cmp_v [8];
  logic [127:0] cmp_flat;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  bit [15:0] m_cnt;
  bit [1:0]  m_act [8];
  bit        m_lat [8];
  bit        m_flg [8];

  always #10 clk = ~clk;

  always_comb
    for (int n = 0; n < 8; n++) cmp_flat[n*16 +: 16] = cmp_v[n];

  oc_pin_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cmp_flat_i(cmp_flat),
    .mask_i(mask), .flag_clr_i(clr), .port_dir_i(dir), .port_data_i(dat),
    .pin_o(pin), .pin_oe_o(oe), .match_flag_o(flg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_rd(input bit a);
    if (a == 1'b0) return {m_act[7], m_act[6], m_act[5], m_act[4]};
    return {m_act[3], m_act[2], m_act[1], m_act[0]};
  endfunction

  task automatic compare();
    logic [7:0] e_pin, e_oe, e_flg;
    for (int n = 0; n < 8; n++) begin
      bit live;
      live     = (m_act[n] != 2'b00) && !mask[n];
      e_oe[n]  = live ? 1'b1 : dir[n];
      e_pin[n] = live ? m_lat[n] : dat[n];
      e_flg[n] = m_flg[n];
    end
    chk("R1 R2 readback", {24'b0, rdata}, {24'b0, m_rd(addr[0])});
    chk("R5 R7 direction", {24'b0, oe}, {24'b0, e_oe});
    chk("R3 R4 R6 R8 pin", {24'b0, pin}, {24'b0, e_pin});
    chk("R9 flags", {24'b0, flg}, {24'b0, e_flg});
  endtask

  task automatic advance();
    for (int n = 0; n < 8; n++) begin
      bit hit, live;
      hit  = (cmp_v[n] == m_cnt);
      live = (m_act[n] != 2'b00) && !mask[n];
      if (hit && live) begin
        case (m_act[n])
          2'b01: m_lat[n] = !m_lat[n];
          2'b10: m_lat[n] = 1'b0;
          2'b11: m_lat[n] = 1'b1;
          default: ;
        endcase
      end
      m_flg[n] = hit || (m_flg[n] && !clr[n]);
    end
    if (we) begin
      if (addr[0] == 1'b0)
        for (int k = 0; k < 4; k++) m_act[4+k] = wdata[2*k +: 2];
      else
        for (int k = 0; k < 4; k++) m_act[k] = wdata[2*k +: 2];
    end
    m_cnt = m_cnt + 16'd1;
  endtask

  task automatic step();
    #1;
    compare();
    advance();
    @(negedge clk);
  endtask

  task automatic run(input int k);
    for (int i = 0; i < k; i++) step();
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
  endtask

  initial begin
    for (int n = 0; n < 8; n++) begin
      cmp_v[n] = 16'hFFFF; m_act[n] = 2'b00; m_lat[n] = 1'b0; m_flg[n] = 1'b0;
    end
    m_cnt = '0;
    dir = 8'hA5; dat = 8'h3C;
    repeat (2) @(negedge clk);
    // reset state (R1, R7, R8, R9)
    addr = 1'b0; #1;
    chk("R1 reset reg0", {24'b0, rdata}, 32'h0);
    addr = 1'b1; #1;
    chk("R1 reset reg1", {24'b0, rdata}, 32'h0);
    chk("R9 reset flags", {24'b0, flg}, 32'h0);
    chk("R7 reset passthrough oe", {24'b0, oe}, 32'hA5);
    chk("R7 reset passthrough pin", {24'b0, pin}, 32'h3C);
    @(negedge clk);
    rst_n = 1'b1;
    addr = 1'b0;

    run(4);
    // R2 packing: ch7 toggle, ch6 clear, ch5 set, ch4 off / ch3 set, ch2 toggle, ch1 off, ch0 clear
    wr(1'b0, 8'b01_10_11_00);
    wr(1'b1, 8'b11_01_00_10);
    addr = 1'b0; step();
    addr = 1'b1; step();
    dir = 8'h00;
    for (int n = 0; n < 8; n++) cmp_v[n] = m_cnt + 16'(5 + n);
    run(20);

    // toggle channel 7 twice (R3)
    cmp_v[7] = m_cnt + 16'd2; run(4);
    cmp_v[7] = m_cnt + 16'd2; run(4);

    // match and clear in the same cycle: flag stays (R9)
    cmp_v[0] = m_cnt + 16'd3;
    while (m_cnt != cmp_v[0]) step();
    clr = 8'h01; step(); clr = 8'h00;
    #1 chk("R9 set wins over clear", {31'b0, flg[0]}, 32'd1);
    clr = 8'hFF; step(); clr = 8'h00;
    #1 chk("R9 cleared", {24'b0, flg}, 32'h0);

    // mask veto (R6)
    mask = 8'hF0; dir = 8'h0F; dat = 8'h55;
    for (int n = 0; n < 8; n++) cmp_v[n] = m_cnt + 16'(3 + n);
    run(16);
    mask = 8'h00;

    // code rewrite without a match leaves latch (R8): ch4 off -> set
    cmp_v[4] = m_cnt + 16'd200;
    wr(1'b0, 8'b01_10_11_11);
    #1 chk("R8 new code, latch still 0", {31'b0, pin[4]}, 32'd0);
    chk("R5 now driven", {31'b0, oe[4]}, 32'd1);
    run(3);

    // random traffic
    for (int i = 0; i < 600; i++) begin
      int c;
      mask  = 8'($urandom);
      dir   = 8'($urandom);
      dat   = 8'($urandom);
      clr   = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      we    = ($urandom % 6 == 0);
      addr  = 1'($urandom);
      wdata = 8'($urandom);
      c = int'($urandom % 8);
      cmp_v[c] = m_cnt + 16'($urandom % 5);
      step();
    end
    we = 1'b0;
    run(4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R4 watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule